// File: doc/BRIEF.md
# Module Clock Mode Manager

This block sits between software and one peripheral module and decides when the module's mandatory clocks run. Software writes a 2-bit mode: 0 turns the module off and 2 turns it on. Codes 1 and 3 are reserved and a write of either is dropped. The block runs the wake and sleep handshake with the module through an idle request output and an idle acknowledge input. It also accepts a wake request from the module, which can cancel a sleep that is still in progress. It reports what it is doing on a read-only 2-bit status.

The status can show four things: fully running, in transition, interface idle, or off. In the interface-idle state the interface clock is gated because the domain asked for it, but the functional clock keeps running. While the mode is enabled the block holds a veto that stops the power domain from sleeping. Interconnect accesses that arrive while the status shows off get an error response one cycle later. The exception is an access tagged as coming from an asynchronous wakeup of the module, which gets no error.

A warm reset clears the mode but leaves the status state machine where it was. Only the cold reset returns the status to off.

Top module: `modclk_mgr`

## Requirements
- R1: After cold reset the mode is 0, the status is 3 (off), the functional and interface clock enables are 0, the veto is 0, the idle request is 1 and the access error is 0.
- R2: A write of 0 or 2 sets the mode at the next clock edge. A write of 1 or 3 leaves the mode unchanged.
- R3: When the mode becomes 2 while the status is 3, the status goes to 1 with the idle request low and both clock enables high. It stays at 1 until the idle acknowledge is low, then it goes to 0.
- R4: When the mode becomes 0 while the status is 0 and no wake request is present, the status goes to 1 with the idle request high. It stays at 1 until the idle acknowledge is high, then it goes to 3 and both clock enables drop.
- R5: While the status is 0 and the mode is 2, a raised domain-idle input moves the status to 2, which gates the interface clock but keeps the functional clock. Lowering that input returns the status to 0.
- R6: A wake request during a sleep handshake that has not yet been acknowledged aborts the sleep. The status stays at 1 with the idle request low, then goes to 0 once the idle acknowledge is low, and it holds 0 while the wake request stays high. If the idle acknowledge and the wake request arrive in the same cycle, the acknowledge wins and the status goes to 3.
- R7: The access error is raised in the cycle after an access only when the status was 3 and the access was not tagged as an asynchronous wakeup. It is never raised otherwise.
- R8: The sleep veto equals 1 exactly when the mode is 2.
- R9: A warm reset returns the mode to 0 and drops the veto at the next edge. It does not reset the status, which continues from its current state.
- R10: The functional clock enable is 1 whenever the status is not 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high cold reset |
| warm_rst | input | 1 | Synchronous active-high warm reset; clears the mode only |
| cfg_wr | input | 1 | Mode write strobe |
| cfg_wdata | input | 2 | Mode value to write |
| mode | output | 2 | Current mode (0 off, 2 on) |
| status | output | 2 | Status: 0 running, 1 transition, 2 interface idle, 3 off |
| idle_req | output | 1 | Idle request to the module |
| idle_ack | input | 1 | Idle acknowledge from the module |
| wake_req | input | 1 | Wake request from the module |
| dom_idle | input | 1 | Domain asks to gate interface clocks |
| fclk_en | output | 1 | Functional clock enable |
| iclk_en | output | 1 | Interface clock enable |
| sleep_veto | output | 1 | Blocks power-domain sleep |
| acc_valid | input | 1 | Interconnect access strobe |
| acc_wake | input | 1 | Access results from an asynchronous wakeup |
| acc_err | output | 1 | Error response for the access of the previous cycle |

## Verification
The assertions assume the module follows the handshake: it lowers the idle acknowledge only after the idle request falls, and it raises the acknowledge only while the idle request is high. They also assume the wake-request and access-tag inputs are stable across each clock edge. The stimulus drives every input at the falling edge and moves the acknowledge only in response to the idle request the bench has already observed. Reserved mode codes are written on purpose, since the design must drop them.

// File: rtl/modclk_pkg.sv
package modclk_pkg;
  localparam int MODE_W = 2;
  localparam int STAT_W = 2;

  localparam logic [MODE_W-1:0] MODE_OFF = 2'd0;
  localparam logic [MODE_W-1:0] MODE_ON  = 2'd2;

  localparam logic [STAT_W-1:0] STAT_RUN    = 2'd0;
  localparam logic [STAT_W-1:0] STAT_TRANS  = 2'd1;
  localparam logic [STAT_W-1:0] STAT_IFIDLE = 2'd2;
  localparam logic [STAT_W-1:0] STAT_OFF    = 2'd3;

  typedef enum logic [2:0] {
    S_OFF    = 3'd0,
    S_WAKE   = 3'd1,
    S_RUN    = 3'd2,
    S_IFIDLE = 3'd3,
    S_SLEEP  = 3'd4
  } fsm_t;

  function automatic logic [STAT_W-1:0] status_of(fsm_t s);
    case (s)
      S_RUN:    return STAT_RUN;
      S_IFIDLE: return STAT_IFIDLE;
      S_WAKE,
      S_SLEEP:  return STAT_TRANS;
      default:  return STAT_OFF;
    endcase
  endfunction
endpackage

// File: rtl/modclk_mode_reg.sv
module modclk_mode_reg
  import modclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              warm_rst,
  input  logic              wr,
  input  logic [MODE_W-1:0] wdata,
  output logic [MODE_W-1:0] mode_q,
  output logic              veto_q
);
  logic legal;
  assign legal = (wdata == MODE_OFF) || (wdata == MODE_ON);

  always_ff @(posedge clk) begin
    if (rst || warm_rst) begin
      mode_q <= MODE_OFF;
      veto_q <= 1'b0;
    end else if (wr && legal) begin
      mode_q <= wdata;
      veto_q <= (wdata == MODE_ON);
    end
  end
endmodule

// File: rtl/modclk_status_fsm.sv
module modclk_status_fsm
  import modclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic              idle_ack,
  input  logic              wake_req,
  input  logic              dom_idle,
  output logic [STAT_W-1:0] status_q,
  output logic              idle_req_q,
  output logic              fclk_en_q,
  output logic              iclk_en_q
);
  fsm_t state_q, state_d;
  logic on;
  assign on = (mode == MODE_ON);

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_OFF:    if (on) state_d = S_WAKE;
      S_WAKE:   if (!idle_ack) state_d = S_RUN;
      S_RUN: begin
        if (!on && !wake_req)   state_d = S_SLEEP;
        else if (on && dom_idle) state_d = S_IFIDLE;
      end
      S_IFIDLE: begin
        if (!on)           state_d = S_SLEEP;
        else if (!dom_idle) state_d = S_RUN;
      end
      S_SLEEP: begin
        if (idle_ack)      state_d = S_OFF;
        else if (wake_req) state_d = S_WAKE;
      end
      default: state_d = S_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_OFF;
      status_q   <= STAT_OFF;
      idle_req_q <= 1'b1;
      fclk_en_q  <= 1'b0;
      iclk_en_q  <= 1'b0;
    end else begin
      state_q    <= state_d;
      status_q   <= status_of(state_d);
      idle_req_q <= (state_d == S_OFF) || (state_d == S_SLEEP);
      fclk_en_q  <= (state_d != S_OFF);
      iclk_en_q  <= (state_d == S_WAKE) || (state_d == S_RUN) || (state_d == S_SLEEP);
    end
  end
endmodule

// File: rtl/modclk_acc_guard.sv
module modclk_acc_guard
  import modclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] status,
  input  logic              acc_valid,
  input  logic              acc_wake,
  output logic              acc_err_q
);
  always_ff @(posedge clk) begin
    if (rst) acc_err_q <= 1'b0;
    else     acc_err_q <= acc_valid && !acc_wake && (status == STAT_OFF);
  end
endmodule

// File: rtl/modclk_mgr.sv
module modclk_mgr
  import modclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              warm_rst,
  input  logic              cfg_wr,
  input  logic [MODE_W-1:0] cfg_wdata,
  output logic [MODE_W-1:0] mode,
  output logic [STAT_W-1:0] status,
  output logic              idle_req,
  input  logic              idle_ack,
  input  logic              wake_req,
  input  logic              dom_idle,
  output logic              fclk_en,
  output logic              iclk_en,
  output logic              sleep_veto,
  input  logic              acc_valid,
  input  logic              acc_wake,
  output logic              acc_err
);
  modclk_mode_reg u_mode (
    .clk(clk), .rst(rst), .warm_rst(warm_rst), .wr(cfg_wr), .wdata(cfg_wdata),
    .mode_q(mode), .veto_q(sleep_veto)
  );

  modclk_status_fsm u_fsm (
    .clk(clk), .rst(rst), .mode(mode), .idle_ack(idle_ack), .wake_req(wake_req),
    .dom_idle(dom_idle), .status_q(status), .idle_req_q(idle_req),
    .fclk_en_q(fclk_en), .iclk_en_q(iclk_en)
  );

  modclk_acc_guard u_guard (
    .clk(clk), .rst(rst), .status(status), .acc_valid(acc_valid),
    .acc_wake(acc_wake), .acc_err_q(acc_err)
  );
endmodule

// File: rtl/modclk_mgr_chk.sv
module modclk_mgr_chk
  import modclk_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              warm_rst,
  input logic [MODE_W-1:0] mode,
  input logic [STAT_W-1:0] status,
  input logic              idle_req,
  input logic              fclk_en,
  input logic              iclk_en,
  input logic              sleep_veto,
  input logic              acc_valid,
  input logic              acc_wake,
  input logic              acc_err
);
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst) (mode == MODE_OFF) || (mode == MODE_ON)); // R2
  AST_VETO_MODE: assert property (@(posedge clk) disable iff (rst) sleep_veto == (mode == MODE_ON)); // R8
  AST_FCLK_LIVE: assert property (@(posedge clk) disable iff (rst) (status != STAT_OFF) |-> fclk_en); // R10
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst) (status == STAT_OFF) |-> (!fclk_en && !iclk_en && idle_req)); // R4
  AST_IFIDLE_GATE: assert property (@(posedge clk) disable iff (rst) (status == STAT_IFIDLE) |-> (fclk_en && !iclk_en)); // R5
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst) acc_err |-> ($past(status) == STAT_OFF && $past(acc_valid) && !$past(acc_wake))); // R7
  AST_WARM_MODE: assert property (@(posedge clk) disable iff (rst) $past(warm_rst) |-> (mode == MODE_OFF && !sleep_veto)); // R9
endmodule

bind modclk_mgr modclk_mgr_chk u_chk (
  .clk(clk), .rst(rst), .warm_rst(warm_rst), .mode(mode), .status(status),
  .idle_req(idle_req), .fclk_en(fclk_en), .iclk_en(iclk_en), .sleep_veto(sleep_veto),
  .acc_valid(acc_valid), .acc_wake(acc_wake), .acc_err(acc_err)
);

// File: tb/modclk_mgr_bench.sv
`timescale 1ns/1ps
module modclk_mgr_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic warm_rst = 1'b0;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_wdata = 2'd0;
  logic idle_ack = 1'b1;
  logic wake_req = 1'b0;
  logic dom_idle = 1'b0;
  logic acc_valid = 1'b0;
  logic acc_wake = 1'b0;
  logic [1:0] mode, status;
  logic idle_req, fclk_en, iclk_en, sleep_veto, acc_err;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  modclk_mgr u_modclk_mgr (
    .clk(clk), .rst(rst), .warm_rst(warm_rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .mode(mode), .status(status), .idle_req(idle_req), .idle_ack(idle_ack),
    .wake_req(wake_req), .dom_idle(dom_idle), .fclk_en(fclk_en), .iclk_en(iclk_en),
    .sleep_veto(sleep_veto), .acc_valid(acc_valid), .acc_wake(acc_wake), .acc_err(acc_err)
  );

  // stimulus {wr, wdata[1:0], ack, wake, dom_idle, acc_valid, acc_wake}
  // expected {mode[1:0], status[1:0], idle_req, fclk, iclk, veto, err}, then tag number
  localparam int NV = 18;
  localparam logic [20:0] VEC [NV] = '{
    {8'b00010010, 9'b001110001, 4'd7},  // R7 access while off errors
    {8'b00010011, 9'b001110000, 4'd7},  // R7 wakeup-tagged access passes
    {8'b10110000, 9'b001110000, 4'd2},  // R2 reserved 1 dropped
    {8'b11010000, 9'b101110010, 4'd8},  // R8 enable raises veto
    {8'b00010000, 9'b100101110, 4'd3},  // R3 waking
    {8'b00000000, 9'b100001110, 4'd3},  // R3 running after ack low
    {8'b00000010, 9'b100001110, 4'd7},  // R7 access while running
    {8'b00000100, 9'b101001010, 4'd5},  // R5 interface idle
    {8'b11100100, 9'b101001010, 4'd2},  // R2 reserved 3 dropped
    {8'b00000000, 9'b100001110, 4'd5},  // R5 back to running
    {8'b10000000, 9'b000001100, 4'd8},  // R8 disable drops veto
    {8'b00000000, 9'b000111100, 4'd4},  // R4 sleeping
    {8'b00001000, 9'b000101100, 4'd6},  // R6 abort
    {8'b00001000, 9'b000001100, 4'd6},  // R6 back to running
    {8'b00001000, 9'b000001100, 4'd6},  // R6 held by wake
    {8'b00000000, 9'b000111100, 4'd4},  // R4 sleep again
    {8'b00010000, 9'b001110000, 4'd4},  // R4 off after ack
    {8'b00010010, 9'b001110001, 4'd7}   // R7 error again
  };

  task automatic check(input int tag, input logic [8:0] exp);
    logic [8:0] act;
    act = {mode, status, idle_req, fclk_en, iclk_en, sleep_veto, acc_err};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #100000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    step(); step();
    rst = 1'b0;
    check(1, 9'b001110000);  // R1 reset state
    for (int k = 0; k < NV; k++) begin
      {cfg_wr, cfg_wdata, idle_ack, wake_req, dom_idle, acc_valid, acc_wake} = VEC[k][20:13];
      step();
      check(int'(VEC[k][3:0]), VEC[k][12:4]);
    end
    {cfg_wr, cfg_wdata, idle_ack, wake_req, dom_idle, acc_valid, acc_wake} = 8'b11010000;
    step();
    cfg_wr = 1'b0;
    step();
    idle_ack = 1'b0;
    step();
    check(3, 9'b100001110);  // R3 running again
    warm_rst = 1'b1;
    step();
    warm_rst = 1'b0;
    check(9, 9'b000001100);  // R9 mode cleared, status kept
    step();
    check(10, 9'b000111100); // R10 fclk on while in transition
    wake_req = 1'b1;
    idle_ack = 1'b1;
    step();
    wake_req = 1'b0;
    check(6, 9'b001110000);  // R6 ack wins over wake
    cfg_wr = 1'b1;
    cfg_wdata = 2'd2;
    step();
    cfg_wr = 1'b0;
    step();
    rst = 1'b1;
    step();
    rst = 1'b0;
    check(1, 9'b001110000);  // R1 cold reset mid-wake
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule